// File: doc/BRIEF.md
# One-Time-Pad Shared-Bus Line Cipher

This block sits between a bus agent's cache and a shared snooping bus. Every transfer on the bus carries a global transaction sequence number that each agent keeps in step by counting all transfers it sees. The block encrypts a line the agent sends when it holds the bus, and decrypts a line it snoops from another agent. In both cases it XORs the line with a one-time pad, which is a keyed function of the current sequence number and a per-process key.

Computing a pad takes several cycles. To keep that delay off the transfer path, the block fills a small ring of pads ahead of time. The ring covers the current sequence number and the sequence numbers just above it. Each slot is tagged with its sequence number. Once the current number has moved past a slot's tag, that slot is overwritten with a pad further ahead. When the pad for the current number is not yet in the ring, the block raises a miss flag and holds the transfer until the pad arrives.

A three-state machine controls the transfers. `ST_UNINIT` is the state after reset, before the sequence number has been loaded. `ST_READY` accepts transfers. `ST_STALL` holds one transfer whose pad is still being computed. The transitions are:
- init-load: `ST_UNINIT` to `ST_READY` on a load.
- hit: `ST_READY` to `ST_READY` when a transfer finds its pad.
- miss: `ST_READY` to `ST_STALL` when a transfer does not find its pad.
- fill: `ST_STALL` to `ST_READY` when the pad lands.
- reload: `ST_READY` or `ST_STALL` to `ST_READY` on a load, which drops any held transfer.

Top module: `otp_bus_cipher`

## Requirements
- R1: After reset, `cur_seq` is 0 and `out_valid`, `stall` and `pad_miss` are low. Until the first `seq_load`, transfer requests produce no output and leave `cur_seq` unchanged.
- R2: A `seq_load` sets `cur_seq` to `seq_init` on the next edge, discards every pre-computed pad and every pad still being computed, and drops any held transfer.
- R3: For each 64-bit lane j (bits 64j+63..64j), the pad is built from the sequence number s and the key words Kw = `proc_key[64w+63:64w]`:
  - a = s ^ K[j mod 4]
  - b = rotl(a,13) + K[(j+1) mod 4]
  - c = b ^ (b>>7) ^ (0x9E3779B97F4A7C15·(j+1) mod 2^64)
  - lane = rotl(c,29) + s
  
  All additions are modulo 2^64.
- R4: An emitted line equals the input line XOR pad(`out_seq`, key), and `out_seq` is the sequence number that was current when the line was accepted. Applying the same XOR to a ciphertext gives back the plaintext.
- R5: Each accepted transfer, sent (`xfer_snoop`=0) or snooped (`xfer_snoop`=1), raises `cur_seq` by exactly one. `out_snoop` repeats the kind of the transfer.
- R6: When the pad is in the ring, `out_valid` is high for one cycle on the edge after the request, and `pad_miss` stays low.
- R7: When the pad is missing, `pad_miss` pulses for one cycle and `stall` rises on the edge after the request. While stalled, the request inputs are ignored. Once the pad is computed, the held line is emitted and `stall` falls.
- R8: Once the ring has filled, the block accepts transfers back to back, one per cycle, for longer than the ring depth, with no miss.
- R9: The sequence number wraps from 2^64−1 to 0, and pads and tags stay correct across the wrap.
- R10: A new `proc_key` applied together with a `seq_load` is used for every pad computed after that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| seq_load | input | 1 | load the sequence number and flush the pads |
| seq_init | input | 64 | value loaded into the sequence number |
| proc_key | input | 256 | per-process key |
| xfer_valid | input | 1 | a transfer occurs this cycle |
| xfer_snoop | input | 1 | 0 = own send on grant, 1 = snooped line |
| xfer_data | input | 256 | line to encrypt or decrypt |
| stall | output | 1 | a transfer is held, waiting for its pad |
| pad_miss | output | 1 | one-cycle pulse when a transfer finds no pad |
| out_valid | output | 1 | output line valid |
| out_snoop | output | 1 | kind of the emitted transfer |
| out_data | output | 256 | line XOR pad |
| out_seq | output | 64 | sequence number used for the emitted line |
| cur_seq | output | 64 | current bus sequence number |

## Verification
The bench builds the block with its default parameters: a ring of 8 slots, 256-bit lines, a 256-bit key and 64-bit sequence numbers. With 8 slots, a burst of 12 back-to-back transfers runs past the ring depth and reuses every slot, so the refill lead is exercised. The full 64-bit sequence width allows a load just below the maximum, which brings the wrap and the modular tag comparison into reach. A request made right after a load is sure to miss, which exercises the stall path together with ignored inputs.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int unsigned LANE_W = 64;
    localparam logic [63:0] LANE_MULT = 64'h9E37_79B9_7F4A_7C15;

    typedef enum logic [1:0] {
        ST_UNINIT,
        ST_READY,
        ST_STALL
    } xfer_state_e;

    function automatic logic [63:0] rotl64(input logic [63:0] v, input int unsigned n);
        return (v << n) | (v >> (64 - n));
    endfunction

endpackage

// File: rtl/otp_pad_pipe.sv
module otp_pad_pipe #(
    parameter int unsigned SEQ_W  = 64,
    parameter int unsigned KEY_W  = 256,
    parameter int unsigned DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [KEY_W-1:0]  key,
    output logic              out_valid,
    output logic [SEQ_W-1:0]  out_seq,
    output logic [DATA_W-1:0] out_pad
);
    import otp_pkg::*;

    localparam int unsigned LANES  = DATA_W / LANE_W;
    localparam int unsigned KWORDS = KEY_W / LANE_W;
    localparam int unsigned STAGES = 4;

    logic [STAGES-1:0] v_q;
    logic [SEQ_W-1:0]  seq_q [STAGES];
    logic [DATA_W-1:0] x1_d, x2_d, x3_d, x4_d;
    logic [DATA_W-1:0] x1_q, x2_q, x3_q, x4_q;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int unsigned KA = j % KWORDS;
        localparam int unsigned KB = (j + 1) % KWORDS;
        localparam logic [63:0] LC = LANE_MULT * 64'(j + 1);
        logic [63:0] t2;
        assign t2 = x2_q[j*LANE_W +: LANE_W];
        assign x1_d[j*LANE_W +: LANE_W] = 64'(in_seq) ^ key[KA*LANE_W +: LANE_W];
        assign x2_d[j*LANE_W +: LANE_W] = rotl64(x1_q[j*LANE_W +: LANE_W], 13)
                                          + key[KB*LANE_W +: LANE_W];
        assign x3_d[j*LANE_W +: LANE_W] = t2 ^ (t2 >> 7) ^ LC;
        assign x4_d[j*LANE_W +: LANE_W] = rotl64(x3_q[j*LANE_W +: LANE_W], 29)
                                          + 64'(seq_q[2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else if (flush) begin
            v_q <= '0;
        end else begin
            v_q <= {v_q[STAGES-2:0], in_valid};
        end
    end

    always_ff @(posedge clk) begin
        x1_q     <= x1_d;
        x2_q     <= x2_d;
        x3_q     <= x3_d;
        x4_q     <= x4_d;
        seq_q[0] <= in_seq;
        for (int s = 1; s < STAGES; s++) begin
            seq_q[s] <= seq_q[s-1];
        end
    end

    assign out_valid = v_q[STAGES-1];
    assign out_seq   = seq_q[STAGES-1];
    assign out_pad   = x4_q;

endmodule

// File: rtl/otp_pad_queue.sv
module otp_pad_queue #(
    parameter int unsigned SEQ_W  = 64,
    parameter int unsigned KEY_W  = 256,
    parameter int unsigned DATA_W = 256,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_load,
    input  logic [SEQ_W-1:0]  seq_init,
    input  logic [SEQ_W-1:0]  cur_seq,
    input  logic [KEY_W-1:0]  key,
    output logic              hit,
    output logic [DATA_W-1:0] pad
);
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam logic [SEQ_W-1:0] WINDOW = SEQ_W'(DEPTH);

    logic              active;
    logic [SEQ_W-1:0]  nxt_issue;
    logic [SEQ_W-1:0]  issue_ahead;
    logic              issue_en;

    logic              p_valid;
    logic [SEQ_W-1:0]  p_seq;
    logic [DATA_W-1:0] p_pad;
    logic [SEQ_W-1:0]  fill_ahead;
    logic              fill_ok;

    logic [DEPTH-1:0]  slot_v;
    logic [SEQ_W-1:0]  slot_tag [DEPTH];
    logic [DATA_W-1:0] slot_pad [DEPTH];
    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W-1:0]  fill_idx;

    assign issue_ahead = nxt_issue - cur_seq;
    assign issue_en    = active && (issue_ahead < WINDOW);

    otp_pad_pipe #(
        .SEQ_W  (SEQ_W),
        .KEY_W  (KEY_W),
        .DATA_W (DATA_W)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (seq_load),
        .in_valid  (issue_en),
        .in_seq    (nxt_issue),
        .key       (key),
        .out_valid (p_valid),
        .out_seq   (p_seq),
        .out_pad   (p_pad)
    );

    assign fill_ahead = p_seq - cur_seq;
    assign fill_ok    = p_valid && (fill_ahead < WINDOW);
    assign fill_idx   = p_seq[IDX_W-1:0];
    assign cur_idx    = cur_seq[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            nxt_issue <= '0;
            slot_v    <= '0;
        end else if (seq_load) begin
            active    <= 1'b1;
            nxt_issue <= seq_init;
            slot_v    <= '0;
        end else begin
            if (issue_en) begin
                nxt_issue <= nxt_issue + 1'b1;
            end
            if (fill_ok) begin
                slot_v[fill_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_ok) begin
            slot_tag[fill_idx] <= p_seq;
            slot_pad[fill_idx] <= p_pad;
        end
    end

    assign hit = slot_v[cur_idx] && (slot_tag[cur_idx] == cur_seq);
    assign pad = slot_pad[cur_idx];

endmodule

// File: rtl/otp_xfer_fsm.sv
module otp_xfer_fsm #(
    parameter int unsigned SEQ_W  = 64,
    parameter int unsigned DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_load,
    input  logic [SEQ_W-1:0]  seq_init,
    input  logic              xfer_valid,
    input  logic              xfer_snoop,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic              pad_hit,
    input  logic [DATA_W-1:0] pad,
    output logic [SEQ_W-1:0]  cur_seq,
    output logic              stall,
    output logic              pad_miss,
    output logic              out_valid,
    output logic              out_snoop,
    output logic [DATA_W-1:0] out_data,
    output logic [SEQ_W-1:0]  out_seq
);
    import otp_pkg::*;

    xfer_state_e       state, nxt;
    logic [DATA_W-1:0] held_data;
    logic              held_snoop;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_UNINIT: nxt = seq_load ? ST_READY : ST_UNINIT;
            ST_READY: begin
                if (seq_load)                   nxt = ST_READY;
                else if (xfer_valid && !pad_hit) nxt = ST_STALL;
                else                             nxt = ST_READY;
            end
            ST_STALL: begin
                if (seq_load || pad_hit) nxt = ST_READY;
                else                     nxt = ST_STALL;
            end
            default: nxt = ST_UNINIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNINIT;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_seq    <= '0;
            pad_miss   <= 1'b0;
            out_valid  <= 1'b0;
            out_snoop  <= 1'b0;
            out_data   <= '0;
            out_seq    <= '0;
            held_data  <= '0;
            held_snoop <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            pad_miss  <= 1'b0;
            if (seq_load) begin
                cur_seq <= seq_init;
            end else begin
                unique case (state)
                    ST_UNINIT: ;
                    ST_READY: begin
                        if (xfer_valid && pad_hit) begin
                            out_valid <= 1'b1;
                            out_snoop <= xfer_snoop;
                            out_data  <= xfer_data ^ pad;
                            out_seq   <= cur_seq;
                            cur_seq   <= cur_seq + 1'b1;
                        end else if (xfer_valid) begin
                            pad_miss   <= 1'b1;
                            held_data  <= xfer_data;
                            held_snoop <= xfer_snoop;
                        end
                    end
                    ST_STALL: begin
                        if (pad_hit) begin
                            out_valid <= 1'b1;
                            out_snoop <= held_snoop;
                            out_data  <= held_data ^ pad;
                            out_seq   <= cur_seq;
                            cur_seq   <= cur_seq + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign stall = (state == ST_STALL);

endmodule

// File: rtl/otp_bus_cipher.sv
module otp_bus_cipher #(
    parameter int unsigned SEQ_W  = 64,
    parameter int unsigned KEY_W  = 256,
    parameter int unsigned DATA_W = 256,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_load,
    input  logic [SEQ_W-1:0]  seq_init,
    input  logic [KEY_W-1:0]  proc_key,
    input  logic              xfer_valid,
    input  logic              xfer_snoop,
    input  logic [DATA_W-1:0] xfer_data,
    output logic              stall,
    output logic              pad_miss,
    output logic              out_valid,
    output logic              out_snoop,
    output logic [DATA_W-1:0] out_data,
    output logic [SEQ_W-1:0]  out_seq,
    output logic [SEQ_W-1:0]  cur_seq
);
    logic              pad_hit;
    logic [DATA_W-1:0] pad;

    otp_pad_queue #(
        .SEQ_W  (SEQ_W),
        .KEY_W  (KEY_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_load (seq_load),
        .seq_init (seq_init),
        .cur_seq  (cur_seq),
        .key      (proc_key),
        .hit      (pad_hit),
        .pad      (pad)
    );

    otp_xfer_fsm #(
        .SEQ_W  (SEQ_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_load   (seq_load),
        .seq_init   (seq_init),
        .xfer_valid (xfer_valid),
        .xfer_snoop (xfer_snoop),
        .xfer_data  (xfer_data),
        .pad_hit    (pad_hit),
        .pad        (pad),
        .cur_seq    (cur_seq),
        .stall      (stall),
        .pad_miss   (pad_miss),
        .out_valid  (out_valid),
        .out_snoop  (out_snoop),
        .out_data   (out_data),
        .out_seq    (out_seq)
    );

endmodule

// File: rtl/otp_bus_cipher_chk.sv
module otp_bus_cipher_chk #(
    parameter int unsigned SEQ_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seq_load,
    input logic [SEQ_W-1:0] seq_init,
    input logic [SEQ_W-1:0] cur_seq,
    input logic             stall,
    input logic             pad_miss,
    input logic             out_valid,
    input logic [SEQ_W-1:0] out_seq
);
    logic seen_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        seen_load <= 1'b0;
        else if (seq_load) seen_load <= 1'b1;
    end

    a_r1_quiet_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_load |-> (!out_valid && !stall && !pad_miss));

    a_r2_load_sets_seq: assert property (@(posedge clk) disable iff (!rst_n)
        seq_load |=> (cur_seq == $past(seq_init) && !out_valid && !stall));

    a_r5_seq_steps_per_output: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_load |=> (cur_seq == $past(cur_seq) + SEQ_W'(out_valid)));

    a_r4_out_seq_was_current: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_load ##1 out_valid) |-> (out_seq == $past(cur_seq)));

    a_r7_miss_enters_stall: assert property (@(posedge clk) disable iff (!rst_n)
        pad_miss |-> stall);

    a_r7_no_output_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !out_valid);

endmodule

bind otp_bus_cipher otp_bus_cipher_chk #(.SEQ_W(SEQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_load  (seq_load),
    .seq_init  (seq_init),
    .cur_seq   (cur_seq),
    .stall     (stall),
    .pad_miss  (pad_miss),
    .out_valid (out_valid),
    .out_seq   (out_seq)
);

// File: tb/otp_bus_cipher_bench.sv
`timescale 1ns/1ps
module otp_bus_cipher_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seq_load = 1'b0;
    logic [63:0]  seq_init = '0;
    logic [255:0] proc_key = '0;
    logic         xfer_valid = 1'b0;
    logic         xfer_snoop = 1'b0;
    logic [255:0] xfer_data = '0;
    logic         stall, pad_miss, out_valid, out_snoop;
    logic [255:0] out_data;
    logic [63:0]  out_seq, cur_seq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [255:0] KEY_A = 256'h0f1e2d3c4b5a6978_8796a5b4c3d2e1f0_1122334455667788_99aabbccddeeff00;
    localparam logic [255:0] KEY_B = 256'hdeadbeefcafef00d_0123456789abcdef_fedcba9876543210_a5a55a5a3c3cc3c3;

    always #2.5 clk = ~clk;

    otp_bus_cipher u_otp_bus_cipher (
        .clk(clk), .rst_n(rst_n), .seq_load(seq_load), .seq_init(seq_init),
        .proc_key(proc_key), .xfer_valid(xfer_valid), .xfer_snoop(xfer_snoop),
        .xfer_data(xfer_data), .stall(stall), .pad_miss(pad_miss),
        .out_valid(out_valid), .out_snoop(out_snoop), .out_data(out_data),
        .out_seq(out_seq), .cur_seq(cur_seq)
    );

    function automatic logic [255:0] pad_f(input logic [63:0] s, input logic [255:0] k);
        logic [255:0] r;
        for (int j = 0; j < 4; j++) begin
            logic [63:0] a, b, c, lc;
            a  = s ^ k[j*64 +: 64];
            b  = {a[50:0], a[63:51]} + k[((j + 1) % 4)*64 +: 64];
            lc = 64'h9E37_79B9_7F4A_7C15 * 64'(j + 1);
            c  = b ^ (b >> 7) ^ lc;
            r[j*64 +: 64] = {c[34:0], c[63:35]} + s;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_seq(input logic [63:0] s, input logic [255:0] k);
        @(negedge clk);
        proc_key = k;
        seq_init = s;
        seq_load = 1'b1;
        @(negedge clk);
        seq_load = 1'b0;
        chk(cur_seq == s, "R2 load value", 256'(cur_seq), 256'(s));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one transfer expected to hit; called right after a negedge
    task automatic xfer_hit(input bit snp, input logic [255:0] d, input logic [255:0] exp_d,
                            input logic [63:0] s, input string req);
        xfer_valid = 1'b1;
        xfer_snoop = snp;
        xfer_data  = d;
        @(negedge clk);
        xfer_valid = 1'b0;
        chk(out_valid == 1'b1, {req, " R6 out_valid"}, 256'(out_valid), 256'(1));
        chk(pad_miss == 1'b0, {req, " R6 no miss"}, 256'(pad_miss), 256'(0));
        chk(out_data == exp_d, {req, " R4 data"}, out_data, exp_d);
        chk(out_seq == s, {req, " R4 seq"}, 256'(out_seq), 256'(s));
        chk(out_snoop == snp, {req, " R5 kind"}, 256'(out_snoop), 256'(snp));
        chk(cur_seq == s + 64'd1, {req, " R5 step"}, 256'(cur_seq), 256'(s + 64'd1));
    endtask

    task automatic t_reset;
        chk(cur_seq == 64'd0, "R1 reset seq", 256'(cur_seq), 256'(0));
        chk(!out_valid && !stall && !pad_miss, "R1 reset flags",
            256'({out_valid, stall, pad_miss}), 256'(0));
        @(negedge clk);
        xfer_valid = 1'b1;
        xfer_data  = 256'h1234;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!out_valid && !stall, "R1 ignored before load", 256'({out_valid, stall}), 256'(0));
            chk(cur_seq == 64'd0, "R1 seq unchanged", 256'(cur_seq), 256'(0));
        end
        xfer_valid = 1'b0;
    endtask

    task automatic t_cold_miss;
        logic [63:0]  s0 = 64'h1234_abcd_0000_001e;
        logic [255:0] d  = 256'hfeed_0001_0002_0003_0004_0005_0006_0007_0008_0009_000a_000b_000c_000d_000e_000f;
        int waited = 0;
        load_seq(s0, KEY_A);
        xfer_valid = 1'b1;
        xfer_snoop = 1'b0;
        xfer_data  = d;
        @(negedge clk);
        chk(pad_miss == 1'b1, "R7 miss pulse", 256'(pad_miss), 256'(1));
        chk(stall == 1'b1, "R7 stall raised", 256'(stall), 256'(1));
        xfer_snoop = 1'b1;
        xfer_data  = ~d;
        while (!out_valid && waited < 30) begin
            @(negedge clk);
            waited++;
            if (!out_valid)
                chk(pad_miss == 1'b0, "R7 miss is one pulse", 256'(pad_miss), 256'(0));
        end
        xfer_valid = 1'b0;
        chk(out_valid == 1'b1, "R7 held line emitted", 256'(out_valid), 256'(1));
        chk(stall == 1'b0, "R7 stall released", 256'(stall), 256'(0));
        chk(out_data == (d ^ pad_f(s0, KEY_A)), "R7 R3 held data used", out_data, d ^ pad_f(s0, KEY_A));
        chk(out_snoop == 1'b0, "R7 held kind used", 256'(out_snoop), 256'(0));
        chk(cur_seq == s0 + 64'd1, "R7 single step", 256'(cur_seq), 256'(s0 + 64'd1));
    endtask

    task automatic t_warm_roundtrip;
        logic [63:0]  s = cur_seq;
        logic [255:0] p = 256'h0bad_f00d_5555_aaaa_1111_2222_3333_4444_6666_7777_8888_9999_cccc_dddd_eeee_ffff;
        logic [255:0] c;
        idle(12);
        c = p ^ pad_f(s, KEY_A);
        xfer_hit(1'b0, p, c, s, "send");
        @(negedge clk);
        xfer_hit(1'b1, p ^ pad_f(s + 64'd1, KEY_A), p, s + 64'd1, "R4 snoop decrypt");
    endtask

    task automatic t_burst;
        logic [63:0] s = cur_seq;
        idle(12);
        xfer_valid = 1'b1;
        for (int i = 0; i < 12; i++) begin
            logic [255:0] d = {8{32'(i * 32'h01010101 + 32'h5a)}};
            xfer_snoop = i[0];
            xfer_data  = d;
            @(negedge clk);
            chk(out_valid && !pad_miss && !stall, "R8 back-to-back hit",
                256'({out_valid, pad_miss, stall}), 256'(3'b100));
            chk(out_data == (d ^ pad_f(s + 64'(i), KEY_A)), "R8 burst data",
                out_data, d ^ pad_f(s + 64'(i), KEY_A));
            chk(out_seq == s + 64'(i), "R8 burst seq", 256'(out_seq), 256'(s + 64'(i)));
        end
        xfer_valid = 1'b0;
        chk(cur_seq == s + 64'd12, "R5 burst count", 256'(cur_seq), 256'(s + 64'd12));
    endtask

    task automatic t_wrap;
        logic [63:0] s = 64'hffff_ffff_ffff_fffe;
        load_seq(s, KEY_A);
        idle(12);
        for (int i = 0; i < 3; i++) begin
            logic [63:0]  si = s + 64'(i);
            logic [255:0] d  = {4{64'hc0de_0000_0000_0000 + 64'(i)}};
            xfer_hit(1'b0, d, d ^ pad_f(si, KEY_A), si, "R9 wrap");
        end
        chk(cur_seq == 64'd1, "R9 wrapped seq", 256'(cur_seq), 256'(1));
    endtask

    task automatic t_key_change;
        logic [63:0]  s = 64'h0000_0042_0000_0000;
        logic [255:0] d = 256'h3;
        load_seq(s, KEY_B);
        idle(12);
        xfer_hit(1'b0, d, d ^ pad_f(s, KEY_B), s, "R10 new key");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_miss();
        t_warm_roundtrip();
        t_burst();
        t_wrap();
        t_key_change();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule